// File: doc/BRIEF.md
# Parallel Self-Synchronous Lane Descrambler

This block undoes the scrambling applied to one serial lane after 8b/10b decoding, working on a 16-bit word per clock. Each recovered bit is the received bit XORed with the received scrambled bits 14 and 15 positions earlier in serial order, so the generator is 1 + x^14 + x^15. The feedback history is built only from received scrambled bits. No seed has to be exchanged, and the block recovers by itself after a line bit error.

A word enters with a valid strobe and leaves one clock later with its own valid strobe. A runtime bypass input makes selected words pass through unchanged. The history keeps updating during bypass, so descrambling can be turned back on at any word with no resync time. A synchronous reset clears the history and the output stage.

Top module: `lane_descrambler`

## Requirements
- R1: While `srst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_data` = 0. The history is cleared to zero, so the first word after reset is descrambled against an all-zero history.
- R2: For a valid word with `bypass` low, each output bit equals the input bit XOR the received bits 14 and 15 positions earlier in the serial stream.
- R3: Within a word, bit 15 is the earliest in serial order and bit 0 the latest. Starting from zero history, the word 16'h8000 descrambles to 16'h8003.
- R4: A cycle with `in_valid` low does not change the history, and `out_data` holds its previous value on the following cycle.
- R5: `out_valid` equals `in_valid` delayed by exactly one clock, in both the descramble and bypass paths.
- R6: A valid word presented with `bypass` high appears on `out_data` unchanged one clock later.
- R7: The history also loads from words received in bypass. A descrambled word that follows bypassed words uses those words as its history.
- R8: After a single corrupted input bit, every output word from the second word after the corrupted one matches the original plaintext again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| in_data | input | 16 | Scrambled word, bit 15 earliest in serial order |
| in_valid | input | 1 | Qualifies `in_data` |
| bypass | input | 1 | When high, the word passes through unchanged |
| out_data | output | 16 | Descrambled (or bypassed) word, one clock after input |
| out_valid | output | 1 | Qualifies `out_data` |

## Verification
The bench aims at bit ordering inside the word. A design that unrolled the recursion with bit 0 first would turn 16'h8000 into a value other than 16'h8003 and would disagree with a serial reference model on random data. Idle gaps between valid words are included: a history that advanced on invalid cycles would corrupt the word after each gap. Bypass is toggled word by word: a history frozen during bypass would show up as wrong data on the first descrambled word afterwards. A bit is flipped in a stream scrambled in the bench, and the bench checks that the plaintext returns within two words. A design that fed back its own output instead of the received bits would stay wrong after that error.

// File: rtl/lane_dscr_pkg.sv
package lane_dscr_pkg;
   // Default geometry of the descrambler: word width and generator taps.
   localparam int unsigned WORD_W_DEF   = 16;
   localparam int unsigned TAP_NEAR_DEF = 14;
   localparam int unsigned TAP_FAR_DEF  = 15;
endpackage

// File: rtl/lane_dscr_hist.sv
// Holds the most recent received scrambled bits; advances only on valid words.
module lane_dscr_hist #(
   parameter int unsigned W  = 16,
   parameter int unsigned HL = 15
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          load,
   input  logic [W-1:0]  din,
   output logic [HL-1:0] hist
);
   logic [HL-1:0] hist_nxt;

   generate
      if (W >= HL) begin : g_wide
         // A whole word refills the history.
         assign hist_nxt = din[HL-1:0];
      end else begin : g_narrow
         // Shift the new word in behind the older bits.
         assign hist_nxt = {hist[HL-W-1:0], din};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (srst)      hist <= '0;
      else if (load) hist <= hist_nxt;
   end
endmodule

// File: rtl/lane_dscr_xor.sv
// Unrolled parallel descramble: bit i uses stream bits i+NEAR and i+FAR,
// where the stream vector is {history, word} with its MSB earliest.
module lane_dscr_xor #(
   parameter int unsigned W    = 16,
   parameter int unsigned NEAR = 14,
   parameter int unsigned FAR  = 15
) (
   input  logic [FAR-1:0] hist,
   input  logic [W-1:0]   din,
   output logic [W-1:0]   dout
);
   localparam int unsigned EXT_W = FAR + W;
   logic [EXT_W-1:0] ext;

   assign ext = {hist, din};

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = ext[i] ^ ext[i + NEAR] ^ ext[i + FAR];
   end
endmodule

// File: rtl/lane_dscr_out.sv
// Output register: selects raw or descrambled word, holds while idle.
module lane_dscr_out #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         vld,
   input  logic         byp,
   input  logic [W-1:0] raw,
   input  logic [W-1:0] dsc,
   output logic [W-1:0] q,
   output logic         q_vld
);
   logic [W-1:0] sel;

   assign sel = byp ? raw : dsc;

   always_ff @(posedge clk) begin
      if (srst) begin
         q     <= '0;
         q_vld <= 1'b0;
      end else begin
         q_vld <= vld;
         if (vld) q <= sel;
      end
   end
endmodule

// File: rtl/lane_descrambler.sv
module lane_descrambler
   import lane_dscr_pkg::*;
#(
   parameter int unsigned W        = WORD_W_DEF,
   parameter int unsigned TAP_NEAR = TAP_NEAR_DEF,
   parameter int unsigned TAP_FAR  = TAP_FAR_DEF
) (
   input  logic         clk,
   input  logic         srst,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   input  logic         bypass,
   output logic [W-1:0] out_data,
   output logic         out_valid
);
   localparam int unsigned HL = TAP_FAR;

   generate
      if (W < 1) begin : g_bad_w
         $error("lane_descrambler: W must be at least 1");
      end
      if (TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR) begin : g_bad_taps
         $error("lane_descrambler: need 0 < TAP_NEAR < TAP_FAR");
      end
   endgenerate

   logic [HL-1:0] hist;
   logic [W-1:0]  dsc;

   lane_dscr_hist #(.W(W), .HL(HL)) u_hist (
      .clk  (clk),
      .srst (srst),
      .load (in_valid),
      .din  (in_data),
      .hist (hist)
   );

   lane_dscr_xor #(.W(W), .NEAR(TAP_NEAR), .FAR(TAP_FAR)) u_xor (
      .hist (hist),
      .din  (in_data),
      .dout (dsc)
   );

   lane_dscr_out #(.W(W)) u_out (
      .clk   (clk),
      .srst  (srst),
      .vld   (in_valid),
      .byp   (bypass),
      .raw   (in_data),
      .dsc   (dsc),
      .q     (out_data),
      .q_vld (out_valid)
   );
endmodule

// File: rtl/lane_descrambler_chk.sv
module lane_descrambler_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         srst,
   input logic [W-1:0] in_data,
   input logic         in_valid,
   input logic         bypass,
   input logic [W-1:0] out_data,
   input logic         out_valid
);
   // R1: reset clears the output stage
   a_r1_reset_clears: assert property (@(posedge clk)
      srst |=> (!out_valid && out_data == '0));

   // R5: valid follows input valid by one clock
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (srst)
      in_valid |=> out_valid);

   // R5: idle input gives idle output one clock later
   a_r5_idle_follows: assert property (@(posedge clk) disable iff (srst)
      !in_valid |=> !out_valid);

   // R4: data holds across an idle cycle
   a_r4_hold_idle: assert property (@(posedge clk) disable iff (srst)
      !in_valid |=> $stable(out_data));

   // R6: bypassed word appears unchanged
   a_r6_bypass_raw: assert property (@(posedge clk) disable iff (srst)
      (in_valid && bypass) |=> (out_data == $past(in_data)));
endmodule

bind lane_descrambler lane_descrambler_chk #(.W(W)) u_chk (.*);

// File: tb/sim_lane_descrambler.sv
module sim_lane_descrambler;
   logic        clk = 1'b0;
   logic        srst;
   logic [15:0] in_data;
   logic        in_valid;
   logic        bypass;
   logic [15:0] out_data;
   logic        out_valid;

   int total = 0;
   int fails = 0;

   logic [14:0] mh;        // reference history, bit 0 most recent
   logic [14:0] sh;        // bench scrambler state
   logic [15:0] last_out;

   always #10 clk = ~clk;  // 50 MHz

   lane_descrambler u0 (
      .clk(clk), .srst(srst), .in_data(in_data), .in_valid(in_valid),
      .bypass(bypass), .out_data(out_data), .out_valid(out_valid)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // Serial reference, one bit at a time, earliest bit first.
   task automatic model(input logic [15:0] d, output logic [15:0] e);
      for (int i = 15; i >= 0; i--) begin
         e[i] = d[i] ^ mh[13] ^ mh[14];
         mh   = {mh[13:0], d[i]};
      end
   endtask

   task automatic scramble(input logic [15:0] p, output logic [15:0] s);
      for (int i = 15; i >= 0; i--) begin
         s[i] = p[i] ^ sh[13] ^ sh[14];
         sh   = {sh[13:0], s[i]};
      end
   endtask

   task automatic do_reset();
      srst = 1'b1; in_valid = 1'b0; bypass = 1'b0; in_data = '0;
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid", {15'b0, out_valid}, 16'h0);
      chk(out_data == 16'h0, "R1 data", out_data, 16'h0);
      srst = 1'b0; mh = '0; sh = '0; last_out = '0;
   endtask

   task automatic step(input logic [15:0] d, input logic v, input logic b,
                       input string tag);
      logic [15:0] e;
      in_data = d; in_valid = v; bypass = b;
      if (v) begin
         model(d, e);
         if (b) e = d;
      end else begin
         e = last_out;
      end
      @(posedge clk); @(negedge clk);
      chk(out_valid == v, "R5 valid", {15'b0, out_valid}, {15'b0, v});
      chk(out_data == e, tag, out_data, e);
      last_out = out_data;
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] p, s;
      void'($urandom(32'd1234));
      srst = 1'b1; in_valid = 1'b0; bypass = 1'b0; in_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      do_reset();

      // R3: bit ordering, from zero history (R1)
      step(16'h8000, 1'b1, 1'b0, "R3 order");
      chk(out_data == 16'h8003, "R3 constant", out_data, 16'h8003);

      // R2 directed patterns
      step(16'hFFFF, 1'b1, 1'b0, "R2 ones");
      step(16'h0000, 1'b1, 1'b0, "R2 zeros");
      step(16'hA5A5, 1'b1, 1'b0, "R2 pattern");

      // R4: idle gap must not move history or output
      step(16'h1234, 1'b0, 1'b0, "R4 idle hold");
      step(16'hFFFF, 1'b0, 1'b1, "R4 idle hold bypass");
      step(16'h5A5A, 1'b1, 1'b0, "R4 after gap");

      // R6/R7: bypass then descramble
      step(16'hC3C3, 1'b1, 1'b1, "R6 bypass");
      step(16'h0F0F, 1'b1, 1'b1, "R6 bypass");
      step(16'h0000, 1'b1, 1'b0, "R7 history from bypass");

      // Random mix
      for (int k = 0; k < 400; k++) begin
         logic v, b;
         v = ($urandom % 4) != 0;
         b = ($urandom % 5) == 0;
         step(16'($urandom), v, b,
              !v ? "R4 random idle" : (b ? "R6 random" : "R2 random"));
      end

      // R8: recovery after a bit error
      do_reset();
      for (int k = 0; k < 12; k++) begin
         p = 16'($urandom);
         scramble(p, s);
         if (k == 4) s[7] = ~s[7];
         step(s, 1'b1, 1'b0, "R2 stream");
         if (k != 4 && k != 5)
            chk(out_data == p, "R8 recovery", out_data, p);
      end

      summary();
      $finish;
   end
endmodule